// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the serial slave side and instruction decoder of a serial flash device. It runs on a fast system clock, watches the serial clock, chip-select, hold and data-in pins for edges, and gathers 8-bit cycles (one opcode, then address bytes, then data bytes) that arrive most significant bit first. Response bytes go out the same way on a data-out pin with a separate output-enable. It serves status reads, the write-enable and write-disable commands and two identification reads. Program, erase and status-write commands are turned into one-cycle requests for the array and status blocks that sit beside it.

A command is acted on only when chip-select rises exactly at the end of a byte, after exactly the number of bytes that the opcode needs. Each modifying command also needs the write-enable latch to be set at that moment. The latch clears when a neighbouring block reports that an operation has finished, or when a write-disable command arrives. A low hold input freezes the serial transfer midway. It turns off the data-out driver and resets nothing.

Top module: `spi_flash_front`

## Requirements
- R1: Data-in is sampled on rising serial-clock edges and data-out changes on falling edges. Both idle-low (mode 0) and idle-high (mode 3) framing work. Edges seen while chip-select is high are ignored.
- R2: A frame is acted on only if chip-select rises with a whole number of bytes received and that number equals the opcode's length. The lengths are: 06h/04h is 1 byte, 60h/C7h is 1, 01h is 2, 20h/52h/D8h is 4, 02h is 5 and ADh is 6. Any other frame is discarded.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it. The latch is status bit 1.
- R4: A valid modifying frame with the latch set raises req_valid for exactly one cycle, on the clock edge that sees chip-select high. req_kind is 1 for 02h, 2 for ADh, 3 for 20h, 4 for 52h, 5 for D8h, 6 for 60h/C7h and 7 for 01h. req_addr holds the three address bytes, first byte most significant, and is 0 for status writes and chip erase. req_data holds the data bytes, the first in bits 15:8 for ADh. For 02h the byte is in bits 7:0. For 01h the new status value is in bits 7:0.
- R5: A modifying frame that arrives while the latch is clear produces no request.
- R6: A pulse on op_done clears the write-enable latch.
- R7: After opcode 05h, the status byte {stat_hi[5:0], latch, busy} is sent and then repeated for as long as clocks continue.
- R8: After opcode 9Fh the block sends the manufacturer byte (default BFh), then the 24-bit JEDEC device code from its top byte down. This 4-byte sequence then repeats.
- R9: Opcodes 90h and ABh take three address bytes. If address bit 0 is 0 the manufacturer byte is sent first, and if it is 1 the short device byte is sent first. The two then alternate.
- R10: While hold_n is low, serial-clock edges do not shift data in or out and so_oe is low. The transfer resumes intact when hold_n rises.
- R11: so_oe is high only while chip-select is low, hold_n is high and a response byte has been loaded.
- R12: After reset the latch is clear, and req_valid and so_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip-select, frames a command |
| hold_n | input | 1 | Active-low pause of the transfer |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so |
| busy | input | 1 | Busy flag from the array, status bit 0 |
| stat_hi | input | 6 | Upper status bits from the status block |
| op_done | input | 1 | Pulse: program, erase or status write finished |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | Request code, see R4 |
| req_addr | output | 24 | Request address |
| req_data | output | 16 | Request data |

## Verification
A wrong write-enable latch shows up at the ports within one frame. The next status read returns bit 1 flipped, and the next modifying frame either produces a request that should not be there or drops one that should. A bad bit or byte counter shifts every later response bit by one position, or makes a frame that ends on a byte boundary count as broken. Because of this, the bench mixes exact frames, frames with one byte too few and frames that stop mid-byte, and compares every request against a queue of expected requests. A response byte loaded on the wrong falling edge shows up as a corrupt first byte in status or ID reads, and this is checked in both clock polarities and across a hold pause.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int CNT_W  = 3;

  typedef enum logic [2:0] {
    RQ_NONE      = 3'd0,
    RQ_PROG_BYTE = 3'd1,
    RQ_PROG_AUTO = 3'd2,
    RQ_ERASE_SEC = 3'd3,
    RQ_ERASE_32K = 3'd4,
    RQ_ERASE_64K = 3'd5,
    RQ_ERASE_ALL = 3'd6,
    RQ_STATUS_WR = 3'd7
  } req_kind_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_STRD = 8'h05;
  localparam logic [7:0] OP_STWR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_AUTO = 8'hAD;
  localparam logic [7:0] OP_ES4K = 8'h20;
  localparam logic [7:0] OP_E32K = 8'h52;
  localparam logic [7:0] OP_E64K = 8'hD8;
  localparam logic [7:0] OP_EALA = 8'h60;
  localparam logic [7:0] OP_EALB = 8'hC7;
  localparam logic [7:0] OP_JDID = 8'h9F;
  localparam logic [7:0] OP_IDA  = 8'h90;
  localparam logic [7:0] OP_IDB  = 8'hAB;

  // Request code for a modifying opcode, RQ_NONE for everything else
  function automatic req_kind_t op_kind(input logic [7:0] op);
    case (op)
      OP_PROG:          return RQ_PROG_BYTE;
      OP_AUTO:          return RQ_PROG_AUTO;
      OP_ES4K:          return RQ_ERASE_SEC;
      OP_E32K:          return RQ_ERASE_32K;
      OP_E64K:          return RQ_ERASE_64K;
      OP_EALA, OP_EALB: return RQ_ERASE_ALL;
      OP_STWR:          return RQ_STATUS_WR;
      default:          return RQ_NONE;
    endcase
  endfunction

  // Exact frame length in bytes; 0 marks an opcode that never executes at frame end
  function automatic logic [CNT_W-1:0] op_len(input logic [7:0] op);
    case (op)
      OP_WREN, OP_WRDI, OP_EALA, OP_EALB: return 3'd1;
      OP_STWR:                            return 3'd2;
      OP_ES4K, OP_E32K, OP_E64K:          return 3'd4;
      OP_PROG:                            return 3'd5;
      OP_AUTO:                            return 3'd6;
      default:                            return 3'd0;
    endcase
  endfunction

  // {valid, byte} for the response byte that follows n received bytes
  function automatic logic [8:0] resp_pick(
    input logic [7:0]  op,
    input logic [2:0]  n,
    input logic [1:0]  rix,
    input logic        a0,
    input logic [7:0]  stat,
    input logic [7:0]  mfr,
    input logic [23:0] jdev,
    input logic [7:0]  sdev
  );
    logic [7:0] b;
    case (op)
      OP_STRD: return {(n != 3'd0), stat};
      OP_JDID: begin
        case (rix)
          2'd0:    b = mfr;
          2'd1:    b = jdev[23:16];
          2'd2:    b = jdev[15:8];
          default: b = jdev[7:0];
        endcase
        return {(n != 3'd0), b};
      end
      OP_IDA, OP_IDB: begin
        b = (a0 ^ rix[0]) ? sdev : mfr;
        return {(n >= 3'd4), b};
      end
      default: return 9'h000;
    endcase
  endfunction

endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
  import spi_front_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             hold_n,
  input  logic             si,
  output logic             bit_fall,
  output logic             byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CNT_W-1:0] byte_cnt,
  output logic [2:0]       bitcnt,
  output logic             frame_end
);

  logic                sck_q;
  logic                cs_q;
  logic                live;
  logic                bit_rise;
  logic [BYTE_W-2:0]   rx_sh;

  assign live      = ~cs_n & hold_n;
  assign bit_rise  = live & sck & ~sck_q;
  assign bit_fall  = live & ~sck & sck_q;
  assign frame_end = cs_n & ~cs_q;
  assign byte_done = bit_rise & (bitcnt == 3'd7);
  assign rx_byte   = {rx_sh, si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      bitcnt   <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bitcnt   <= '0;
        byte_cnt <= '0;
      end else if (bit_rise) begin
        rx_sh  <= {rx_sh[BYTE_W-3:0], si};
        bitcnt <= bitcnt + 3'd1;
        if (byte_done && byte_cnt != {CNT_W{1'b1}})
          byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_front_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [2:0]        bitcnt,
  input  logic              frame_end,
  input  logic              op_done,
  output logic [BYTE_W-1:0] opcode,
  output logic [ADDR_W-1:0] addr,
  output logic              wel,
  output logic              wren_hit,
  output logic              req_valid,
  output logic [2:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);

  logic [DATA_W-1:0] data_q;
  logic              frame_ok;
  logic              wrdi_hit;
  logic              mod_hit;
  req_kind_t         kind;
  req_kind_t         kind_q;

  assign kind     = op_kind(opcode);
  assign frame_ok = frame_end && (bitcnt == 3'd0) && (byte_cnt != '0)
                    && (byte_cnt == op_len(opcode));
  assign wren_hit = frame_ok && (opcode == OP_WREN);
  assign wrdi_hit = frame_ok && (opcode == OP_WRDI);
  assign mod_hit  = frame_ok && (kind != RQ_NONE);
  assign req_kind = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode <= '0;
      addr   <= '0;
      data_q <= '0;
    end else if (cs_n) begin
      opcode <= '0;
      addr   <= '0;
      data_q <= '0;
    end else if (byte_done) begin
      case (byte_cnt)
        3'd0:    opcode       <= rx_byte;
        3'd1:    addr[23:16]  <= rx_byte;
        3'd2:    addr[15:8]   <= rx_byte;
        3'd3:    addr[7:0]    <= rx_byte;
        default: data_q       <= {data_q[BYTE_W-1:0], rx_byte};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      req_valid <= 1'b0;
      kind_q    <= RQ_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      if (wren_hit)
        wel <= 1'b1;
      else if (wrdi_hit || op_done)
        wel <= 1'b0;
      req_valid <= mod_hit & wel;
      if (mod_hit && wel) begin
        kind_q   <= kind;
        req_addr <= (kind == RQ_STATUS_WR || kind == RQ_ERASE_ALL) ? '0 : addr;
        req_data <= (kind == RQ_STATUS_WR) ? {8'h00, addr[23:16]} : data_q;
      end
    end
  end

endmodule

// File: rtl/spi_resp_tx.sv
module spi_resp_tx
  import spi_front_pkg::*;
#(
  parameter logic [7:0]  MFR_ID    = 8'hBF,
  parameter logic [23:0] JEDEC_DEV = 24'h2650A1,
  parameter logic [7:0]  SHORT_DEV = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              bit_fall,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              addr_lsb,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [BYTE_W-1:0] status,
  output logic              so,
  output logic              so_oe
);

  logic              pend;
  logic              resp_act;
  logic [1:0]        rix;
  logic [BYTE_W-1:0] tx;
  logic [8:0]        pick;

  assign pick  = resp_pick(opcode, byte_cnt, rix, addr_lsb, status,
                           MFR_ID, JEDEC_DEV, SHORT_DEV);
  assign so    = tx[BYTE_W-1];
  assign so_oe = resp_act & ~cs_n & hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      resp_act <= 1'b0;
      rix      <= '0;
      tx       <= '0;
    end else if (cs_n) begin
      pend     <= 1'b0;
      resp_act <= 1'b0;
      rix      <= '0;
    end else begin
      if (byte_done)
        pend <= 1'b1;
      else if (bit_fall) begin
        pend <= 1'b0;
        if (pend && pick[8]) begin
          tx       <= pick[7:0];
          resp_act <= 1'b1;
          rix      <= rix + 2'd1;
        end else begin
          tx <= {tx[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spi_front_pkg::*;
#(
  parameter logic [7:0]  MFR_ID    = 8'hBF,
  parameter logic [23:0] JEDEC_DEV = 24'h2650A1,
  parameter logic [7:0]  SHORT_DEV = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        hold_n,
  input  logic        si,
  output logic        so,
  output logic        so_oe,
  input  logic        busy,
  input  logic [5:0]  stat_hi,
  input  logic        op_done,
  output logic        req_valid,
  output logic [2:0]  req_kind,
  output logic [23:0] req_addr,
  output logic [15:0] req_data
);

  logic              bit_fall;
  logic              byte_done;
  logic              frame_end;
  logic              wren_hit;
  logic              wel;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  byte_cnt;
  logic [2:0]        bitcnt;
  logic [BYTE_W-1:0] opcode;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] status;

  assign status = {stat_hi, wel, busy};

  spi_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .bit_fall(bit_fall), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_cnt(byte_cnt), .bitcnt(bitcnt), .frame_end(frame_end)
  );

  spi_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
    .rx_byte(rx_byte), .byte_cnt(byte_cnt), .bitcnt(bitcnt),
    .frame_end(frame_end), .op_done(op_done), .opcode(opcode), .addr(addr),
    .wel(wel), .wren_hit(wren_hit), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data)
  );

  spi_resp_tx #(.MFR_ID(MFR_ID), .JEDEC_DEV(JEDEC_DEV), .SHORT_DEV(SHORT_DEV)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
    .bit_fall(bit_fall), .byte_done(byte_done), .opcode(opcode),
    .addr_lsb(addr[0]), .byte_cnt(byte_cnt), .status(status),
    .so(so), .so_oe(so_oe)
  );

endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so_oe,
  input logic       req_valid,
  input logic       op_done,
  input logic       wel,
  input logic       frame_end,
  input logic       wren_hit,
  input logic [2:0] bitcnt
);

  p_wel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wren_hit |=> wel);

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  p_req_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wel));

  p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !frame_end) |=> !wel);

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hold_n && !cs_n) |-> $stable(bitcnt));

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (!cs_n && hold_n && $past(!cs_n)));

endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .req_valid(req_valid), .op_done(op_done), .wel(wel), .frame_end(frame_end),
  .wren_hit(wren_hit), .bitcnt(bitcnt)
);

// File: tb/sim_spi_flash_front.sv
`timescale 1ns/1ps
module sim_spi_flash_front;

  localparam logic [7:0]  MFR  = 8'hBF;
  localparam logic [23:0] JDEV = 24'h2650A1;
  localparam logic [7:0]  SDEV = 8'h5A;
  localparam logic [5:0]  SHI  = 6'b101101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic        so, so_oe;
  logic        busy = 1'b1;
  logic [5:0]  stat_hi = SHI;
  logic        op_done = 1'b0;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [23:0] req_addr;
  logic [15:0] req_data;

  int checks = 0;
  int fails = 0;
  int unexp = 0;
  int md = 0;
  logic wel_exp = 1'b0;

  typedef struct packed {
    logic [2:0]  k;
    logic [23:0] a;
    logic [15:0] d;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  spi_flash_front #(.MFR_ID(MFR), .JEDEC_DEV(JDEV), .SHORT_DEV(SDEV)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so(so), .so_oe(so_oe), .busy(busy), .stat_hi(stat_hi), .op_done(op_done),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data)
  );

  function automatic logic [7:0] st_exp(input logic w);
    return {SHI, w, 1'b1};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [47:0] act,
                     input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor side of the scoreboard: every request is popped and compared
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        unexp++;
        $display("FAIL R5 unexpected request actual=%h expected=none",
                 {req_kind, req_addr, req_data});
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({req_kind, req_addr, req_data} !== e) begin
          fails++;
          $display("FAIL R4 request actual=%h expected=%h",
                   {req_kind, req_addr, req_data}, e);
        end
      end
    end
  end

  task automatic xbit(input logic b, output logic r);
    @(negedge clk) sck = 1'b0;
    repeat (3) @(negedge clk);
    r = so;
    si = b;
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic bt;
      xbit(b[i], bt);
      r[i] = bt;
    end
  endtask

  task automatic begin_frame();
    @(negedge clk) sck = (md == 3);
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_frame();
    if (md == 0) begin
      @(negedge clk) sck = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Sends n bytes taken from the top of v
  task automatic send(input int n, input logic [47:0] v);
    logic [7:0] r;
    begin_frame();
    for (int i = 0; i < n; i++) xfer(v[47-8*i -: 8], r);
    end_frame();
  endtask

  // Driver side of the scoreboard
  task automatic send_mod(input int n, input logic [47:0] v, input logic [2:0] k,
                          input logic [23:0] a, input logic [15:0] d);
    exp_t e;
    e.k = k; e.a = a; e.d = d;
    if (wel_exp) q.push_back(e);
    send(n, v);
    chk(q.size() == 0, "R4 request delivered", 48'(q.size()), 48'd0);
  endtask

  task automatic rd_status(input string tag);
    logic [7:0] r;
    begin_frame();
    xfer(8'h05, r);
    for (int i = 0; i < 2; i++) begin
      xfer(8'h00, r);
      chk(r == st_exp(wel_exp), tag, 48'(r), 48'(st_exp(wel_exp)));
    end
    chk(so_oe == 1'b1, "R11 oe during read", 48'(so_oe), 48'd1);
    end_frame();
    chk(so_oe == 1'b0, "R11 oe after frame", 48'(so_oe), 48'd0);
  endtask

  task automatic pulse_done();
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
    wel_exp = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    int u0n;
    repeat (3) @(negedge clk);
    chk(so_oe == 1'b0 && req_valid == 1'b0, "R12 reset outputs",
        48'({so_oe, req_valid}), 48'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    md = 0;
    rd_status("R12 R7 status after reset");
    send(1, {8'h06, 40'h0}); wel_exp = 1'b1;
    rd_status("R3 R7 latch set by 06h");

    md = 3;
    send_mod(5, {8'h02, 24'h123456, 8'hA5, 8'h00}, 3'd1, 24'h123456, 16'h00A5);
    rd_status("R1 mode3 status after program");
    pulse_done();
    rd_status("R6 latch cleared by op_done");

    u0n = unexp;
    send_mod(4, {8'h20, 24'h001000, 16'h0}, 3'd3, 24'h001000, 16'h0);
    chk(unexp == u0n, "R5 no request without latch", 48'(unexp), 48'(u0n));

    md = 0;
    send(1, {8'h06, 40'h0}); wel_exp = 1'b1;
    u0n = unexp;
    begin_frame();
    xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h40, r); xfer(8'h11, r);
    for (int i = 0; i < 3; i++) begin
      logic bt;
      xbit(1'b1, bt);
    end
    end_frame();
    send(3, {8'h20, 8'h00, 8'h10, 24'h0});
    send(6, {8'h20, 24'h002000, 16'h0});
    chk(unexp == u0n, "R2 partial or wrong-length frames discarded",
        48'(unexp), 48'(u0n));
    rd_status("R2 latch unchanged by discarded frames");

    send_mod(6, {8'hAD, 24'h000010, 16'h1122}, 3'd2, 24'h000010, 16'h1122);
    md = 3;
    send_mod(1, {8'hC7, 40'h0}, 3'd6, 24'h0, 16'h0);
    send_mod(2, {8'h01, 8'h3C, 32'h0}, 3'd7, 24'h0, 16'h003C);
    send_mod(4, {8'h52, 24'hABCDEF, 16'h0}, 3'd4, 24'hABCDEF, 16'h0);
    md = 0;
    send_mod(4, {8'hD8, 24'h3F0000, 16'h0}, 3'd5, 24'h3F0000, 16'h0);
    send_mod(1, {8'h60, 40'h0}, 3'd6, 24'h0, 16'h0);
    send(1, {8'h04, 40'h0}); wel_exp = 1'b0;
    rd_status("R3 latch cleared by 04h");

    md = 3;
    begin_frame();
    xfer(8'h9F, r);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] e;
      case (i % 4)
        0: e = MFR;
        1: e = JDEV[23:16];
        2: e = JDEV[15:8];
        default: e = JDEV[7:0];
      endcase
      xfer(8'h00, r);
      chk(r == e, "R8 JEDEC id byte", 48'(r), 48'(e));
    end
    end_frame();

    md = 0;
    begin_frame();
    xfer(8'h90, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h01, r);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      chk(r == ((i % 2 == 0) ? SDEV : MFR), "R9 id address 1",
          48'(r), 48'((i % 2 == 0) ? SDEV : MFR));
    end
    end_frame();
    md = 3;
    begin_frame();
    xfer(8'hAB, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
    for (int i = 0; i < 2; i++) begin
      xfer(8'h00, r);
      chk(r == ((i == 0) ? MFR : SDEV), "R9 R1 id address 0",
          48'(r), 48'((i == 0) ? MFR : SDEV));
    end
    end_frame();

    md = 0;
    begin_frame();
    xfer(8'h05, r);
    for (int i = 7; i >= 4; i--) begin
      logic bt;
      xbit(1'b0, bt);
      r[i] = bt;
    end
    @(negedge clk) hold_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(so_oe == 1'b0, "R10 oe off during hold", 48'(so_oe), 48'd0);
    si = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk) sck = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 3; i >= 0; i--) begin
      logic bt;
      xbit(1'b0, bt);
      r[i] = bt;
    end
    chk(r == st_exp(1'b0), "R10 byte intact across hold", 48'(r), 48'(st_exp(1'b0)));
    chk(so_oe == 1'b1, "R10 R11 oe back after hold", 48'(so_oe), 48'd1);
    end_frame();

    chk(q.size() == 0, "R4 scoreboard drained", 48'(q.size()), 48'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule